// File: doc/BRIEF.md
# Bypassable Router Input Queue

This block is the input stage of one router port. A flit that arrives from the link while nothing is waiting and while the switch grants this input is sent to the switch in the same cycle. It is not stored, so the stage adds no latency. A flit that cannot leave at once is placed in a small FIFO. The stored flits then leave in arrival order, and the oldest stored flit always goes ahead of anything newly arriving. The queue is used only under contention.

A registered back-pressure signal tells the upstream sender to stop sending. It rises once the number of stored flits reaches a threshold, which is the depth minus a configurable slack. The slack lets a sender that reacts one cycle late still land its last flit. Because every router stalls its own upstream neighbour in the same way, congestion spreads back hop by hop as far as the traffic source. Routing and arbitration are outside this block. The switch sees a request with its flit and answers with a grant in the same cycle.

Occupancy is tracked by a three-state machine:
- `Q_IDLE`: nothing is stored, and bypass is possible.
- `Q_HOLD`: some flits are stored, but the queue is not full.
- `Q_FULL`: `DEPTH` flits are stored.

Its transitions are:
- IDLE→HOLD: a flit is stored.
- HOLD→IDLE: the last flit is granted with no arrival.
- HOLD→FULL: the last free slot is filled.
- FULL→HOLD: a grant comes with no arrival.
- FULL→FULL: a grant and an arrival come in the same cycle.
- Every state stays where it is when occupancy does not change.

Top module: `byq_port`

## Requirements
- R1: After reset, `sw_req` and `link_stall` are both 0 and nothing is stored.
- R2: While nothing is stored, a flit with `link_valid`=1 and `sw_grant`=1 appears on `sw_flit` with `sw_req`=1 in the same cycle. It is not stored.
- R3: A flit that arrives without a grant, or while earlier flits are stored, is stored. `sw_req` stays 1 for as long as any flit is stored.
- R4: While any flit is stored, `sw_flit` shows the oldest stored flit, even if a new flit is arriving. Flits reach the switch in exactly the order they arrived.
- R5: `link_stall` is registered. In each cycle it equals 1 exactly when, at the end of the previous cycle, the stored count was at least `DEPTH-SLACK`.
- R6: A sender that obeys `link_stall` one cycle late loses no flit. With `SLACK`=1, the queue takes exactly `DEPTH` flits while no grant is given.
- R7: A grant given while `sw_req` is 0 has no effect on the block.
- R8: A flit is removed from the queue only in a cycle in which `sw_grant`=1. In a cycle with both a grant and an arrival, the occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_valid | input | 1 | A flit is present on the link this cycle |
| link_flit | input | DATA_W | Flit from the link |
| link_stall | output | DATA_W==DATA_W?1:1 | Registered back-pressure to the upstream sender |
| sw_req | output | 1 | A flit is offered to the switch |
| sw_flit | output | DATA_W | Flit offered to the switch |
| sw_grant | input | 1 | The switch takes the offered flit this cycle |

## Verification
The bench goes after four corner cases:
- **An arrival coinciding with a stored head.** A design that bypasses too eagerly would let the new flit overtake. The scoreboard then sees the order break.
- **Filling the queue with a sender that reacts late.** A threshold one slot too high would overflow and lose a flit. A threshold one slot too low, or a stall that is combinational, would show up as a mismatch against the expected stall timing.
- **A grant given while nothing is offered.** A design that dequeued blindly would corrupt its pointers, and the next flit would come out wrong.
- **Random mixes of arrivals and grants.** A design that got simultaneous enqueue and dequeue wrong would drift in occupancy, which shows up as wrong stall timing or missing flits.

// File: rtl/byq_pkg.sv
package byq_pkg;
    typedef enum logic [1:0] {
        Q_IDLE = 2'd0,
        Q_HOLD = 2'd1,
        Q_FULL = 2'd2
    } qstate_t;
endpackage

// File: rtl/byq_store.sv
module byq_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= wdata;
    end

    assign head = slots[rd_ptr];

    // R8: occupancy can fall only when a pop was commanded
    a_r8_pop_only_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (count < $past(count)) |-> $past(pop));
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/byq_ctrl.sv
module byq_ctrl
    import byq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SLACK = 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int THRESH = DEPTH - SLACK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             grant,
    input  logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             push,
    output logic             pop,
    output logic             stall
);
    qstate_t          state_q, state_d;
    logic             bypass;
    logic [CNT_W-1:0] cnt_nxt;

    // output process
    always_comb begin
        bypass = 1'b0;
        push   = 1'b0;
        pop    = 1'b0;
        unique case (state_q)
            Q_IDLE: begin
                bypass = in_valid & grant;
                push   = in_valid & ~grant;
            end
            Q_HOLD: begin
                pop  = grant;
                push = in_valid;
            end
            Q_FULL: begin
                pop  = grant;
                push = in_valid & grant;
            end
            default: ;
        endcase
    end

    assign empty   = (state_q == Q_IDLE);
    assign cnt_nxt = count + CNT_W'(push) - CNT_W'(pop);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_IDLE: if (push) state_d = (DEPTH == 1) ? Q_FULL : Q_HOLD;
            Q_HOLD, Q_FULL: begin
                if (cnt_nxt == '0)                state_d = Q_IDLE;
                else if (cnt_nxt == CNT_W'(DEPTH)) state_d = Q_FULL;
                else                              state_d = Q_HOLD;
            end
            default: state_d = Q_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
            stall   <= 1'b0;
        end else begin
            state_q <= state_d;
            stall   <= (cnt_nxt >= CNT_W'(THRESH));
        end
    end

    // R2: bypass happens only with nothing stored
    a_r2_bypass_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (count == '0));
    // R3: the state agrees with the storage count
    a_r3_state_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_IDLE) == (count == '0));
    // R6: a legal sender never hits a full queue without a grant
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && in_valid) |-> grant);
endmodule

// File: rtl/byq_port.sv
module byq_port #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int SLACK  = 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int THRESH = DEPTH - SLACK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_valid,
    input  logic [DATA_W-1:0] link_flit,
    output logic              link_stall,
    output logic              sw_req,
    output logic [DATA_W-1:0] sw_flit,
    input  logic              sw_grant
);
    logic              empty, push, pop;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  count;

    byq_ctrl #(.DEPTH(DEPTH), .SLACK(SLACK)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(link_valid), .grant(sw_grant),
        .count(count), .empty(empty), .push(push), .pop(pop), .stall(link_stall)
    );

    byq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wdata(link_flit), .head(head), .count(count)
    );

    assign sw_req  = link_valid | ~empty;
    assign sw_flit = empty ? link_flit : head;

    // R4: a stored head always wins the switch port
    a_r4_head_first: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (sw_req && sw_flit == head));
    // R5: back-pressure reflects the stored count against the threshold
    a_r5_stall_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        link_stall == (count >= CNT_W'(THRESH)));
    // R7: no grant without request changes storage
    a_r7_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_req && sw_grant) |=> $stable(count));
endmodule

// File: tb/sim_byq_port.sv
module sim_byq_port;
    localparam int DW = 16, DEPTH = 4, SLACK = 1, THRESH = DEPTH - SLACK;

    logic clk = 1'b0, rst_n = 1'b0;
    logic link_valid = 1'b0, sw_grant = 1'b0;
    logic [DW-1:0] link_flit = '0;
    logic link_stall, sw_req;
    logic [DW-1:0] sw_flit;

    int checks = 0, failures = 0;
    logic [DW-1:0] expq[$];
    logic [DW-1:0] seq = 16'h100;
    int prev_occ = 0;
    logic stall_late = 1'b0;
    logic mon_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    byq_port #(.DATA_W(DW), .DEPTH(DEPTH), .SLACK(SLACK)) u0 (
        .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_flit(link_flit),
        .link_stall(link_stall), .sw_req(sw_req), .sw_flit(sw_flit), .sw_grant(sw_grant)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // driver: one cycle; sender obeys stall one cycle late (R6)
    task automatic tick(input bit want, input bit g);
        @(negedge clk);
        sw_grant   = g;
        link_valid = want && !stall_late;
        stall_late = link_stall;
        if (link_valid) begin
            seq++;
            link_flit = seq;
            expq.push_back(seq);
        end else begin
            link_flit = 16'hDEAD;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            check(link_stall == (prev_occ >= THRESH), "R5 stall timing", link_stall, prev_occ >= THRESH);
            check(sw_req == (expq.size() > 0), "R3 request", sw_req, expq.size() > 0);
            if (expq.size() > 0 && sw_req)
                check(sw_flit == expq[0], "R4 order", sw_flit, expq[0]);
            if (sw_req && sw_grant && expq.size() > 0) void'(expq.pop_front());
            prev_occ = expq.size();
        end
    end

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int sent;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!sw_req && !link_stall, "R1 reset", {sw_req, link_stall}, 0);
        mon_on = 1'b1;

        // R2: bypass stream, same-cycle presentation
        for (int i = 0; i < 6; i++) begin
            tick(1, 1);
            #1;
            check(sw_req && sw_flit == seq, "R2 bypass", sw_flit, seq);
        end
        tick(0, 0);
        #1;
        check(!sw_req, "R2 nothing stored", sw_req, 0);

        // R6: fill with no grant, late-reacting sender
        sent = 0;
        for (int i = 0; i < 8; i++) begin
            tick(1, 0);
            if (link_valid) sent++;
        end
        check(sent == DEPTH, "R6 accepted flits", sent, DEPTH);
        check(link_stall, "R5 stall high when full", link_stall, 1);

        // R4: drain while new flits try to arrive
        for (int i = 0; i < 10; i++) tick(1, 1);
        for (int i = 0; i < 6; i++) tick(0, 1);
        check(expq.size() == 0, "R6 nothing lost", expq.size(), 0);
        check(!link_stall, "R5 stall low after drain", link_stall, 0);

        // R7: grant while idle, then hold a flit
        tick(0, 1);
        tick(0, 1);
        tick(1, 0);
        tick(0, 0);
        #1;
        check(sw_req && sw_flit == seq, "R7 idle grant no effect", sw_flit, seq);
        tick(0, 1);
        tick(0, 0);
        #1;
        check(!sw_req, "R8 grant drains one", sw_req, 0);

        // R8: random mix of arrivals and grants
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(lfsr[0] | lfsr[3], lfsr[1] & (lfsr[5] | lfsr[7]));
        end
        for (int i = 0; i < 8; i++) tick(0, 1);
        check(expq.size() == 0, "R8 random drain complete", expq.size(), 0);

        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule